// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block sits between eight level-sensitive shared interrupt request inputs and a bank of 24 global interrupt lines. Lines 0 to 15 feed a legacy interrupt controller and lines 16 to 23 feed an advanced controller. A small byte-wide register port holds one route byte per request input and one power-management control byte. Every output line is the registered OR of every source currently steered to it: the programmable legacy routes, the fixed advanced-controller line owned by each request input, and the system control interrupt (SCI) on whichever line the control byte selects.

Each request input always reaches its own advanced-controller line 16+n, which no other input shares. It also reaches at most one legacy line, chosen by its route byte, and that line may be shared. When software moves the SCI to a different line while the SCI is active, the old line drops and the new line rises one cycle later. The output never shows the SCI on two lines at once. The block also reports the effective route of each request input for status reads. It pulses a notification whenever a route byte is written, so that downstream routing caches can refresh.

Top module: `irq_line_router`

## Requirements
- R1: After a synchronous active-low reset, every route byte holds 0x80, the control byte holds 0x00 so the SCI is on line 9, all outputs `gsi_o` are 0 and `route_chg_o` is 0.
- R2: Register addresses: 0x0 to 0x3 hold the route bytes of inputs 0 to 3, 0x8 to 0xB hold those of inputs 4 to 7, and 0x4 holds the control byte. A write to any other address changes no state and no output.
- R3: Route byte layout: bits [4:0] hold the legacy line number and bit 7 set blocks the input from every legacy line. One cycle after the inputs, legacy output k (k < 16) is the OR of every request input whose bit 7 is clear and whose line field equals k.
- R4: One cycle after the inputs, output 16+n follows request input n, whatever its route byte holds.
- R5: Control byte bits [2:0] select the SCI line. Codes 0, 1, 2, 3 and 4 select lines 9, 10, 11, 20 and 21. The SCI level is ORed into the selected line with the same one-cycle latency.
- R6: With select codes 5, 6 or 7, the SCI input has no effect on any output.
- R7: When a control write changes the selected line while the SCI is high, the output computed in the next cycle has the SCI on no line. From the cycle after that, the SCI appears on the new line.
- R8: The status outputs `route_en_o[n]` and `route_irq_o` have three cases. If bit 7 is set, the route is enabled with line 16+n. If bit 7 is clear and the field is below 16, the route is enabled with that field. If bit 7 is clear and the field is 16 or above, the route is disabled with line 0.
- R9: `route_chg_o` is high for exactly one cycle after each clock edge that captured a write to a route byte address. Control byte writes do not raise it.
- R10: A route field of 16 or above with bit 7 clear steers the input to no legacy line. The input still drives only its own line 16+n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| pirq_in | input | 8 | Shared interrupt request levels, one per input |
| sci_in | input | 1 | System control interrupt level |
| gsi_o | output | 24 | Global interrupt line levels, registered |
| route_chg_o | output | 1 | One-cycle pulse after a route byte write |
| route_en_o | output | 8 | Per-input effective route enabled |
| route_irq_o | output | 40 | Per-input effective line, 5 bits each, input 0 in the low bits |

## Verification
The hardest situation to reach is the SCI reselection break. It requires the SCI to be high at the exact edge that captures a control write, and that write must change the decoded line rather than only rewrite the same code or move between two unused codes. The stimulus holds the SCI high and writes a new select code, then checks the old line, the blank cycle and the new line one after another. It also mixes control writes that change the line, keep it, or select no line into a long run of toggling request and SCI levels, which a behavioural model checks on every clock. A route field of 16 or above is set on purpose to show that such an input reaches neither a legacy line nor any other input's dedicated line.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, types and the SCI select decode used by the
// interrupt line router. Assumes the fixed byte-wide register map below.
package irq_router_pkg;

    localparam int          ROUTE_W      = 8;
    localparam int          FIELD_W      = 5;
    localparam int          BLOCK_BIT    = 7;
    localparam logic [7:0]  ROUTE_RESET  = 8'h80;
    localparam logic [7:0]  CTRL_RESET   = 8'h00;
    localparam logic [3:0]  GRP_LO_BASE  = 4'h0;
    localparam logic [3:0]  GRP_HI_BASE  = 4'h8;
    localparam logic [3:0]  CTRL_ADDR    = 4'h4;
    localparam int          GRP_SIZE     = 4;

    // Selected SCI line: valid flag plus global line number.
    typedef struct packed {
        logic               valid;
        logic [FIELD_W-1:0] line;
    } sci_line_t;

    // Map the three select bits onto a global line, or onto no line.
    function automatic sci_line_t sci_decode(input logic [2:0] sel);
        sci_line_t r;
        r.valid = 1'b1;
        case (sel)
            3'd0:    r.line = 5'd9;
            3'd1:    r.line = 5'd10;
            3'd2:    r.line = 5'd11;
            3'd3:    r.line = 5'd20;
            3'd4:    r.line = 5'd21;
            default: begin
                r.valid = 1'b0;
                r.line  = 5'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
// Route and control byte storage. Decodes the byte address, holds one route
// byte per request input and the control byte, and pulses a notification
// after any route write. Assumes NUM_PIRQ fits two groups of GRP_SIZE.
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [ROUTE_W-1:0]                wr_data,
    output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
    output logic [ROUTE_W-1:0]                ctrl_q,
    output logic                              ctrl_wr,
    output logic                              route_chg_o
);

    logic [NUM_PIRQ-1:0] hit;

    // Per-input address match: low group first, then the high group.
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_hit
        localparam logic [ADDR_W-1:0] MY_ADDR = (n < GRP_SIZE)
            ? ADDR_W'(GRP_LO_BASE) + ADDR_W'(n)
            : ADDR_W'(GRP_HI_BASE) + ADDR_W'(n - GRP_SIZE);
        assign hit[n] = wr_en && (wr_addr == MY_ADDR);

        // Route byte storage for input n.
        always_ff @(posedge clk) begin
            if (!rst_n)      route_q[n] <= ROUTE_RESET;
            else if (hit[n]) route_q[n] <= wr_data;
        end
    end

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= wr_data;
    end

    // Routing-changed pulse, one cycle after a route write.
    always_ff @(posedge clk) begin
        if (!rst_n) route_chg_o <= 1'b0;
        else        route_chg_o <= |hit;
    end

    // R9: the pulse only follows a write strobe.
    p_chg_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_chg_o |-> $past(wr_en));

    // R2: without a write nothing stored moves.
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(route_q) && $stable(ctrl_q)));

endmodule

// File: rtl/irq_sci_select.sv
// SCI line selection. Decodes the control byte and inserts a one-cycle break
// when the line moves while the SCI is high, so that the old line falls
// before the new one rises. Assumes ctrl_q is updated on the ctrl_wr edge.
module irq_sci_select
    import irq_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [ROUTE_W-1:0] wr_data,
    input  logic [ROUTE_W-1:0] ctrl_q,
    input  logic               sci_in,
    output sci_line_t          sci_eff
);

    sci_line_t cur_line;
    sci_line_t new_line;
    logic      moving;
    logic      break_q;

    assign cur_line = sci_decode(ctrl_q[2:0]);
    assign new_line = sci_decode(wr_data[2:0]);
    assign moving   = ctrl_wr && sci_in && (new_line != cur_line);

    // Break flag: high for the cycle that follows a live reselection.
    always_ff @(posedge clk) begin
        if (!rst_n) break_q <= 1'b0;
        else        break_q <= moving;
    end

    // Effective line: suppressed during the break.
    always_comb begin
        sci_eff = cur_line;
        if (break_q) sci_eff.valid = 1'b0;
    end

    // R7: a live reselection leaves the SCI on no line for one cycle.
    p_break_on_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && sci_in && (sci_decode(wr_data[2:0]) != sci_decode(ctrl_q[2:0])))
        |=> !sci_eff.valid);

    // R5: without a control write the effective line does not change.
    p_line_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !$past(ctrl_wr)) |-> $stable(sci_eff.line));

endmodule

// File: rtl/irq_gsi_combine.sv
// Output OR network. Builds every global line from the routed request inputs,
// the dedicated per-input lines and the SCI, then registers the result.
// Assumes NUM_GSI = NUM_LEGACY + NUM_PIRQ and fits in FIELD_W bits.
module irq_gsi_combine
    import irq_router_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    parameter int NUM_GSI    = NUM_LEGACY + NUM_PIRQ
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PIRQ-1:0]               pirq_in,
    input  logic                              sci_in,
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
    input  sci_line_t                         sci_eff,
    output logic [NUM_GSI-1:0]                gsi_q
);

    logic [NUM_GSI-1:0] gsi_d;
    logic [NUM_GSI-1:0] sci_hot;

    // SCI contribution, one line at most.
    for (genvar g = 0; g < NUM_GSI; g++) begin : g_sci
        assign sci_hot[g] = sci_in && sci_eff.valid && (sci_eff.line == FIELD_W'(g));
    end

    // Legacy lines: OR of every unblocked input whose field names the line.
    for (genvar k = 0; k < NUM_LEGACY; k++) begin : g_legacy
        logic [NUM_PIRQ-1:0] src;
        for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_src
            assign src[n] = pirq_in[n] && !route_q[n][BLOCK_BIT]
                         && (route_q[n][FIELD_W-1:0] == FIELD_W'(k));
        end
        assign gsi_d[k] = (|src) || sci_hot[k];
    end

    // Dedicated lines: one per input, unshared.
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_dedicated
        assign gsi_d[NUM_LEGACY+n] = pirq_in[n] || sci_hot[NUM_LEGACY+n];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) gsi_q <= '0;
        else        gsi_q <= gsi_d;
    end

    // R4: each input reaches its own line one cycle later.
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_chk
        p_dedicated_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pirq_in[n] |=> gsi_q[NUM_LEGACY+n]);
    end

    // R6: with no source active and no SCI line, every output is low.
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_in == '0 && !sci_eff.valid) |=> (gsi_q == '0));

endmodule

// File: rtl/irq_route_status.sv
// Effective route report. Turns each route byte into an enabled flag and a
// global line number for status reads. Purely combinational.
module irq_route_status
    import irq_router_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16
) (
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_q,
    output logic [NUM_PIRQ-1:0]               route_en_o,
    output logic [NUM_PIRQ-1:0][FIELD_W-1:0]  route_irq_o
);

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_stat
        logic [FIELD_W-1:0] fld;
        assign fld = route_q[n][FIELD_W-1:0];

        // Three-way route classification for input n.
        always_comb begin
            if (route_q[n][BLOCK_BIT]) begin
                route_en_o[n]  = 1'b1;
                route_irq_o[n] = FIELD_W'(NUM_LEGACY + n);
            end else if (fld < FIELD_W'(NUM_LEGACY)) begin
                route_en_o[n]  = 1'b1;
                route_irq_o[n] = fld;
            end else begin
                route_en_o[n]  = 1'b0;
                route_irq_o[n] = '0;
            end
        end

        // R8: an enabled route is a legacy line or the input's own line.
        always_comb begin
            p_status_legal_r8: assert (!route_en_o[n]
                || route_irq_o[n] < FIELD_W'(NUM_LEGACY)
                || route_irq_o[n] == FIELD_W'(NUM_LEGACY + n));
        end
    end

endmodule

// File: rtl/irq_line_router.sv
// Top level of the shared interrupt line router. Connects register storage,
// SCI selection, the output OR network and the route status report.
// Assumes eight request inputs laid out as two groups of four route bytes.
module irq_line_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PIRQ   = 8,
    parameter int NUM_LEGACY = 16,
    parameter int ADDR_W     = 4,
    localparam int NUM_GSI   = NUM_LEGACY + NUM_PIRQ
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [ROUTE_W-1:0]           wr_data,
    input  logic [NUM_PIRQ-1:0]          pirq_in,
    input  logic                         sci_in,
    output logic [NUM_GSI-1:0]           gsi_o,
    output logic                         route_chg_o,
    output logic [NUM_PIRQ-1:0]          route_en_o,
    output logic [NUM_PIRQ*FIELD_W-1:0]  route_irq_o
);

    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
    logic [ROUTE_W-1:0]               ctrl_q;
    logic                             ctrl_wr;
    sci_line_t                        sci_eff;
    logic [NUM_PIRQ-1:0][FIELD_W-1:0] stat_irq;

    irq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .route_q(route_q), .ctrl_q(ctrl_q),
        .ctrl_wr(ctrl_wr), .route_chg_o(route_chg_o)
    );

    irq_sci_select u_sci (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .sci_in(sci_in), .sci_eff(sci_eff)
    );

    irq_gsi_combine #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY), .NUM_GSI(NUM_GSI)) u_comb (
        .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
        .route_q(route_q), .sci_eff(sci_eff), .gsi_q(gsi_o)
    );

    irq_route_status #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEGACY(NUM_LEGACY)) u_stat (
        .route_q(route_q), .route_en_o(route_en_o), .route_irq_o(stat_irq)
    );

    assign route_irq_o = stat_irq;

endmodule

// File: tb/tb_irq_line_router.sv
`timescale 1ns/1ps
module tb_irq_line_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  pirq_in = '0;
    logic        sci_in = 1'b0;
    logic [23:0] gsi_o;
    logic        route_chg_o;
    logic [7:0]  route_en_o;
    logic [39:0] route_irq_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    bit live   = 0;

    always #2.5 clk = ~clk;

    irq_line_router dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pirq_in(pirq_in), .sci_in(sci_in),
        .gsi_o(gsi_o), .route_chg_o(route_chg_o), .route_en_o(route_en_o),
        .route_irq_o(route_irq_o)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_route [8];
    logic [7:0]  m_ctrl;
    bit          m_break;
    logic [23:0] m_gsi;
    bit          m_chg;

    function automatic int sci_map(input logic [2:0] s);
        case (s)
            3'd0: return 9;
            3'd1: return 10;
            3'd2: return 11;
            3'd3: return 20;
            3'd4: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic int route_index(input logic [3:0] a);
        if (a <= 4'd3) return int'(a);
        if (a >= 4'd8 && a <= 4'd11) return int'(a) - 4;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_route[i]) m_route[i] = 8'h80;
            m_ctrl = 8'h00; m_break = 0; m_gsi = '0; m_chg = 0;
        end else begin
            logic [23:0] g;
            int sl;
            g = '0;
            for (int n = 0; n < 8; n++) begin
                if (pirq_in[n]) begin
                    g[16+n] = 1'b1;
                    if (!m_route[n][7] && m_route[n][4:0] < 16) g[m_route[n][4:0]] = 1'b1;
                end
            end
            sl = sci_map(m_ctrl[2:0]);
            if (sci_in && sl >= 0 && !m_break) g[sl] = 1'b1;
            m_gsi = g;
            m_chg = wr_en && (route_index(wr_addr) >= 0);
            m_break = wr_en && (wr_addr == 4'h4) && sci_in
                      && (sci_map(wr_data[2:0]) != sci_map(m_ctrl[2:0]));
            if (wr_en && route_index(wr_addr) >= 0) m_route[route_index(wr_addr)] = wr_data;
            if (wr_en && wr_addr == 4'h4) m_ctrl = wr_data;
        end
        live = 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (live && !done) begin
            logic [7:0]  e_en;
            logic [39:0] e_irq;
            for (int n = 0; n < 8; n++) begin
                if (m_route[n][7]) begin
                    e_en[n] = 1'b1; e_irq[n*5 +: 5] = 5'(16 + n);
                end else if (m_route[n][4:0] < 16) begin
                    e_en[n] = 1'b1; e_irq[n*5 +: 5] = m_route[n][4:0];
                end else begin
                    e_en[n] = 1'b0; e_irq[n*5 +: 5] = 5'd0;
                end
            end
            check("R3 legacy lines", 64'(gsi_o[15:0]), 64'(m_gsi[15:0]));
            check("R4 dedicated lines", 64'(gsi_o[23:16]), 64'(m_gsi[23:16]));
            check("R9 route change pulse", 64'(route_chg_o), 64'(m_chg));
            check("R8 route status", {16'(route_en_o), 48'(route_irq_o)}, {16'(e_en), 48'(e_irq)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // ---------------- directed and mixed tests ----------------
    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset gsi", 64'(gsi_o), 64'h0);
        check("R1 reset pulse", 64'(route_chg_o), 64'h0);
        check("R1 reset status en", 64'(route_en_o), 64'hFF);
        check("R1 reset status line in0", 64'(route_irq_o[4:0]), 64'd16);
        check("R1 reset status line in7", 64'(route_irq_o[39:35]), 64'd23);

        // R1: SCI defaults to line 9.
        #1 sci_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 default SCI line", 64'(gsi_o), 64'(24'h1 << 9));

        // R7: move SCI from line 9 to line 10 while it is high.
        wr(4'h4, 8'h01);
        @(negedge clk);
        check("R7 old line before break", 64'(gsi_o), 64'(24'h1 << 9));
        @(negedge clk);
        check("R7 break cycle", 64'(gsi_o), 64'h0);
        @(negedge clk);
        check("R7 new line", 64'(gsi_o), 64'(24'h1 << 10));

        // R6: select code 6 means no SCI line.
        wr(4'h4, 8'h06);
        idle(2);
        sci_in = 1'b0; idle(2); sci_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 SCI ignored", 64'(gsi_o), 64'h0);
        sci_in = 1'b0;

        // R2: unmapped address leaves state and outputs alone.
        wr(4'h5, 8'h03);
        @(negedge clk);
        check("R2 no pulse for unmapped", 64'(route_chg_o), 64'h0);
        check("R2 status unchanged", 64'(route_en_o), 64'hFF);

        // R3 and R9: route input 0 to line 5, input 5 to line 5 too.
        wr(4'h0, 8'h05);
        @(negedge clk);
        check("R9 pulse after route write", 64'(route_chg_o), 64'h1);
        @(negedge clk);
        check("R9 pulse one cycle", 64'(route_chg_o), 64'h0);
        wr(4'h9, 8'h05);
        #1 pirq_in = 8'h20;
        @(negedge clk); @(negedge clk);
        check("R3 shared legacy line", 64'(gsi_o), 64'((24'h1 << 5) | (24'h1 << 21)));

        // R10: field 20 with block bit clear reaches no legacy line.
        wr(4'h1, 8'h14);
        #1 pirq_in = 8'h02;
        @(negedge clk); @(negedge clk);
        check("R10 high field not routed", 64'(gsi_o), 64'(24'h1 << 17));
        check("R10 status disabled", 64'(route_en_o[1]), 64'h0);

        // R5: SCI on line 21 ORed with input 5's dedicated line.
        wr(4'h4, 8'h04);
        #1 pirq_in = 8'h00; sci_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 SCI line 21", 64'(gsi_o), 64'(24'h1 << 21));
        sci_in = 1'b0;

        // Mixed traffic, compared against the model each clock.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) begin
                logic [3:0] a;
                a = 4'($urandom_range(0, 15));
                wr(a, 8'($urandom) & 8'h9F);
            end else if (r == 1) begin
                wr(4'h4, 8'($urandom_range(0, 7)));
            end else begin
                @(posedge clk); #1;
                pirq_in = 8'($urandom);
                if (r < 6) sci_in = ~sci_in;
            end
        end
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule